// File: doc/BRIEF.md
# Multi-Stream Slot Allocation Table Updater

This block keeps the time-slot allocation table used by a multi-stream link transmitter. The table has four rows. Each row names a source stream and gives the number of link time slots that stream owns. Software fills a staging (pending) copy of the table one row at a time. It then writes a 2-bit command code to ask for the staging copy to go live. The block moves the staging rows into the live copy only at a frame-header boundary. This means no frame is ever built from a mix of the old and new allocations.

Command code 1 asks for an allocation-change trigger pulse first. At the first frame header after the command, the block raises the trigger for one cycle. At the next frame header it copies the table. Command code 2 skips the trigger and copies the table at the first frame header. In both cases the command readback returns to 0 in the same cycle as the copy. A keepout flag rises at the copy and stays high until 16 more frame headers have gone out. Software polls until both the command readback and the keepout flag read 0, and only then changes bandwidth. Unused rows are programmed as source 0 with 0 slots.

Top module: `mst_alloc_table`

## Requirements
- R1: After reset, every staging and live row holds source 0 and slot count 0. The command readback is 0, and busy, keepout and the trigger pulse are all 0.
- R2: A row write while the block is not busy updates only the addressed staging row (row index on `wr_row`). The live table does not change until an update completes.
- R3: Command code 1 (2'b01) raises `act_pulse` for exactly one cycle, in the cycle after the first frame header that follows the command. The live table does not change at that header.
- R4: Under command code 1, the second frame header copies all staging rows into the live table. In the cycle after that header the command readback reads 0 and busy is 0.
- R5: Command code 2 (2'b10) copies the staging rows at the first frame header after the command, and `act_pulse` never rises.
- R6: From the cycle after an accepted command until the copy, the command readback holds the written code and busy reads 1.
- R7: Row writes to the staging table while busy is 1 are ignored.
- R8: A command write while busy is ignored, and so is command code 3 at any time. Code 0 takes no action.
- R9: Keepout rises in the cycle after the copying frame header. It stays high through 15 further frame headers and falls in the cycle after the 16th.
- R10: The live table changes only in the cycle after a copying frame header. Frame headers with no update pending leave it unchanged.
- R11: A new update that completes while keepout is high restarts the count of 16 frame headers from that copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one staging row |
| wr_row | input | 2 | Row index for the write |
| wr_src | input | 6 | Source stream ID to store |
| wr_slots | input | 6 | Time-slot count to store |
| cmd_wr | input | 1 | Write the update command code |
| cmd_val | input | 2 | Command code: 0 none, 1 with trigger, 2 without trigger |
| frame_hdr | input | 1 | One-cycle pulse for each frame header sent on the link |
| cmd_rd | output | 2 | Command readback; self-clears when the update completes |
| busy | output | 1 | An update is in progress |
| act_pulse | output | 1 | Allocation-change trigger request |
| keepout | output | 1 | High until 16 frame headers have followed the last copy |
| pend_src | output | 24 | Staging source IDs, row r at bits [6r+5:6r] |
| pend_slots | output | 24 | Staging slot counts, row r at bits [6r+5:6r] |
| live_src | output | 24 | Live source IDs, row r at bits [6r+5:6r] |
| live_slots | output | 24 | Live slot counts, row r at bits [6r+5:6r] |

## Verification
The bench looks for an off-by-one in the frame-header sequencing. If the copy happens at the trigger header, the live table changes one header early. If the trigger pulse is dropped or doubled, the trigger count per update is wrong. It counts the keepout window header by header. A counter that ends at 15 or 17 headers, or that is not restarted by a second update, shows up as the wrong flag value at the exact boundary. It also writes rows and commands while an update is pending, and issues the unused code 3. A design that lets these through changes the staging readback or the command readback in a way the bench can see.

// File: rtl/mst_alloc_pkg.sv
package mst_alloc_pkg;
  localparam logic [1:0] CMD_NONE  = 2'd0;
  localparam logic [1:0] CMD_TRIG  = 2'd1;
  localparam logic [1:0] CMD_QUIET = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_TRIG = 2'd1,
    ST_WAIT_COPY = 2'd2
  } upd_state_e;

  // A command starts an update only for the two defined update codes.
  function automatic logic cmd_starts(input logic [1:0] code);
    return (code == CMD_TRIG) || (code == CMD_QUIET);
  endfunction

  // Next keepout header count; wraps to zero when the window closes.
  function automatic int unsigned keep_next(input int unsigned cnt,
                                            input int unsigned limit);
    return (cnt + 1 >= limit) ? 0 : cnt + 1;
  endfunction
endpackage

// File: rtl/alloc_table_regs.sv
module alloc_table_regs #(
  parameter int ROWS   = 4,
  parameter int SRC_W  = 6,
  parameter int SLOT_W = 6,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ROW_W-1:0]        wr_row,
  input  logic [SRC_W-1:0]        wr_src,
  input  logic [SLOT_W-1:0]       wr_slots,
  input  logic                    busy,
  input  logic                    copy_en,
  output logic [ROWS*SRC_W-1:0]   pend_src,
  output logic [ROWS*SLOT_W-1:0]  pend_slots,
  output logic [ROWS*SRC_W-1:0]   live_src,
  output logic [ROWS*SLOT_W-1:0]  live_slots
);
  // Staging writes are accepted only while no update is in flight.
  logic stage_we;
  assign stage_we = wr_en && !busy;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [SRC_W-1:0]  ps_q, ls_q;
    logic [SLOT_W-1:0] pn_q, ln_q;
    logic              hit;
    assign hit = stage_we && (wr_row == ROW_W'(r));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ps_q <= '0; pn_q <= '0;
        ls_q <= '0; ln_q <= '0;
      end else begin
        if (hit) begin
          ps_q <= wr_src;
          pn_q <= wr_slots;
        end
        if (copy_en) begin
          ls_q <= ps_q;
          ln_q <= pn_q;
        end
      end
    end

    assign pend_src  [r*SRC_W  +: SRC_W ] = ps_q;
    assign pend_slots[r*SLOT_W +: SLOT_W] = pn_q;
    assign live_src  [r*SRC_W  +: SRC_W ] = ls_q;
    assign live_slots[r*SLOT_W +: SLOT_W] = ln_q;
  end

  assert_stage_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(pend_src) && $stable(pend_slots)));
  assert_live_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_en |=> ($stable(live_src) && $stable(live_slots)));
  assert_copy_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    copy_en |=> (live_src == $past(pend_src) && live_slots == $past(pend_slots)));
endmodule

// File: rtl/alloc_upd_ctrl.sv
module alloc_upd_ctrl
  import mst_alloc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [1:0] cmd_val,
  input  logic       frame_hdr,
  output logic [1:0] cmd_q,
  output logic       busy,
  output logic       act_pulse,
  output logic       copy_en
);
  upd_state_e st_q;
  logic       act_q;
  logic       accept;

  assign accept    = (st_q == ST_IDLE) && cmd_wr && cmd_starts(cmd_val);
  assign copy_en   = (st_q == ST_WAIT_COPY) && frame_hdr;
  assign busy      = (st_q != ST_IDLE);
  assign act_pulse = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cmd_q <= CMD_NONE;
      act_q <= 1'b0;
    end else begin
      act_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          cmd_q <= cmd_val;
          st_q  <= (cmd_val == CMD_TRIG) ? ST_WAIT_TRIG : ST_WAIT_COPY;
        end
        ST_WAIT_TRIG: if (frame_hdr) begin
          act_q <= 1'b1;
          st_q  <= ST_WAIT_COPY;
        end
        ST_WAIT_COPY: if (frame_hdr) begin
          cmd_q <= CMD_NONE;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_trig_after_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> ($past(frame_hdr) && $past(cmd_q) == CMD_TRIG));
  assert_trig_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |=> !act_q);
  assert_cmd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(copy_en) && cmd_q == CMD_NONE));
  assert_quiet_no_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_QUIET) |-> !act_q);
  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !copy_en) |=> $stable(cmd_q));
  assert_code3_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr && cmd_val == 2'd3) |=> !busy);
endmodule

// File: rtl/alloc_keepout.sv
module alloc_keepout
  import mst_alloc_pkg::*;
#(
  parameter int KEEP_HDRS = 16,
  localparam int CNT_W = $clog2(KEEP_HDRS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic copy_en,
  input  logic frame_hdr,
  output logic keepout
);
  logic [CNT_W-1:0] cnt_q;
  logic             keep_q;
  logic             last_hdr;

  assign last_hdr = keep_q && frame_hdr && (32'(cnt_q) + 1 >= KEEP_HDRS);
  assign keepout  = keep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_q <= 1'b0;
      cnt_q  <= '0;
    end else if (copy_en) begin
      keep_q <= 1'b1;
      cnt_q  <= '0;
    end else if (keep_q && frame_hdr) begin
      cnt_q  <= CNT_W'(keep_next(32'(cnt_q), KEEP_HDRS));
      if (last_hdr) keep_q <= 1'b0;
    end
  end

  assert_keep_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(keepout) |-> $past(copy_en));
  assert_keep_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(keepout) |-> ($past(frame_hdr) && !$past(copy_en)));
  assert_keep_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < KEEP_HDRS);
  assert_keep_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    copy_en |=> (keepout && cnt_q == '0));
endmodule

// File: rtl/mst_alloc_table.sv
module mst_alloc_table #(
  parameter int ROWS      = 4,
  parameter int SRC_W     = 6,
  parameter int SLOT_W    = 6,
  parameter int KEEP_HDRS = 16,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ROW_W-1:0]        wr_row,
  input  logic [SRC_W-1:0]        wr_src,
  input  logic [SLOT_W-1:0]       wr_slots,
  input  logic                    cmd_wr,
  input  logic [1:0]              cmd_val,
  input  logic                    frame_hdr,
  output logic [1:0]              cmd_rd,
  output logic                    busy,
  output logic                    act_pulse,
  output logic                    keepout,
  output logic [ROWS*SRC_W-1:0]   pend_src,
  output logic [ROWS*SLOT_W-1:0]  pend_slots,
  output logic [ROWS*SRC_W-1:0]   live_src,
  output logic [ROWS*SLOT_W-1:0]  live_slots
);
  // Named internal event shared by the three sub-blocks.
  logic copy_en;

  alloc_upd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_val(cmd_val),
    .frame_hdr(frame_hdr), .cmd_q(cmd_rd), .busy(busy),
    .act_pulse(act_pulse), .copy_en(copy_en)
  );

  alloc_table_regs #(.ROWS(ROWS), .SRC_W(SRC_W), .SLOT_W(SLOT_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_src(wr_src), .wr_slots(wr_slots), .busy(busy), .copy_en(copy_en),
    .pend_src(pend_src), .pend_slots(pend_slots),
    .live_src(live_src), .live_slots(live_slots)
  );

  alloc_keepout #(.KEEP_HDRS(KEEP_HDRS)) u_keep (
    .clk(clk), .rst_n(rst_n), .copy_en(copy_en), .frame_hdr(frame_hdr),
    .keepout(keepout)
  );

  assert_copy_on_hdr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    copy_en |-> frame_hdr);
endmodule

// File: tb/mst_alloc_table_tb.sv
module mst_alloc_table_tb;
  localparam int CLK_PERIOD = 10;
  localparam int KEEP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_row = '0;
  logic [5:0] wr_src = '0, wr_slots = '0;
  logic cmd_wr = 1'b0;
  logic [1:0] cmd_val = '0;
  logic frame_hdr = 1'b0;
  logic [1:0] cmd_rd;
  logic busy, act_pulse, keepout;
  logic [23:0] pend_src, pend_slots, live_src, live_slots;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [5:0] e_ps [4];
  logic [5:0] e_pn [4];
  logic [5:0] e_ls [4];
  logic [5:0] e_ln [4];

  // {row[1:0], src[5:0], slots[5:0], cmd[1:0]}
  localparam logic [15:0] VEC [6] = '{
    {2'd0, 6'd3,  6'd10, 2'd1},
    {2'd1, 6'd5,  6'd20, 2'd2},
    {2'd2, 6'd7,  6'd8,  2'd1},
    {2'd3, 6'd63, 6'd4,  2'd2},
    {2'd0, 6'd0,  6'd0,  2'd1},
    {2'd2, 6'd41, 6'd33, 2'd2}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  mst_alloc_table u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_src(wr_src), .wr_slots(wr_slots), .cmd_wr(cmd_wr), .cmd_val(cmd_val),
    .frame_hdr(frame_hdr), .cmd_rd(cmd_rd), .busy(busy), .act_pulse(act_pulse),
    .keepout(keepout), .pend_src(pend_src), .pend_slots(pend_slots),
    .live_src(live_src), .live_slots(live_slots)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pack(input logic [5:0] v [4]);
    logic [23:0] p;
    for (int r = 0; r < 4; r++) p[r*6 +: 6] = v[r];
    return p;
  endfunction

  task automatic check_tables(input string req);
    check({req, " pend_src"},   64'(pend_src),   64'(pack(e_ps)));
    check({req, " pend_slots"}, 64'(pend_slots), 64'(pack(e_pn)));
    check({req, " live_src"},   64'(live_src),   64'(pack(e_ls)));
    check({req, " live_slots"}, 64'(live_slots), 64'(pack(e_ln)));
  endtask

  // All tasks are entered and left at a falling edge.
  task automatic write_row(input logic [1:0] r, input logic [5:0] s, input logic [5:0] n);
    wr_en = 1'b1; wr_row = r; wr_src = s; wr_slots = n;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_cmd(input logic [1:0] c);
    cmd_wr = 1'b1; cmd_val = c;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_val = '0;
  endtask

  task automatic hdr();
    frame_hdr = 1'b1;
    @(negedge clk);
    frame_hdr = 1'b0;
  endtask

  task automatic commit_model();
    for (int r = 0; r < 4; r++) begin e_ls[r] = e_ps[r]; e_ln[r] = e_pn[r]; end
  endtask

  // Run one complete update with checks at each header.
  task automatic run_update(input logic [1:0] c, input string tag);
    write_cmd(c);
    check({tag, " R6 cmd readback"}, 64'(cmd_rd), 64'(c));
    check({tag, " R6 busy"}, 64'(busy), 64'd1);
    if (c == 2'd1) begin
      hdr();
      check({tag, " R3 trigger"}, 64'(act_pulse), 64'd1);
      check_tables({tag, " R3 no copy at trigger"});
      @(negedge clk);
      check({tag, " R3 single pulse"}, 64'(act_pulse), 64'd0);
    end
    hdr();
    commit_model();
    check({tag, " R5/R3 no trigger at copy"}, 64'(act_pulse), 64'd0);
    check_tables({tag, " R4 copied"});
    check({tag, " R4 cmd cleared"}, 64'(cmd_rd), 64'd0);
    check({tag, " R4 not busy"}, 64'(busy), 64'd0);
    check({tag, " R9 keepout rises"}, 64'(keepout), 64'd1);
  endtask

  initial begin
    for (int r = 0; r < 4; r++) begin e_ps[r] = '0; e_pn[r] = '0; e_ls[r] = '0; e_ln[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_tables("R1 reset");
    check("R1 cmd", 64'(cmd_rd), 64'd0);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 keepout", 64'(keepout), 64'd0);
    check("R1 act", 64'(act_pulse), 64'd0);

    // Table-driven updates
    for (int i = 0; i < 6; i++) begin
      logic [15:0] v;
      v = VEC[i];
      write_row(v[15:14], v[13:8], v[7:2]);
      e_ps[v[15:14]] = v[13:8]; e_pn[v[15:14]] = v[7:2];
      check_tables($sformatf("R2 vec%0d staged", i));
      run_update(v[1:0], $sformatf("vec%0d", i));
      for (int k = 0; k < KEEP; k++) hdr();
      check($sformatf("vec%0d R9 keepout clear", i), 64'(keepout), 64'd0);
    end

    // R10: idle headers leave the live table alone
    write_row(2'd1, 6'd9, 6'd9);
    e_ps[1] = 6'd9; e_pn[1] = 6'd9;
    hdr(); hdr();
    check_tables("R10 idle headers");

    // R7 and R8: writes while busy
    write_cmd(2'd1);
    write_row(2'd3, 6'd17, 6'd17);
    check_tables("R7 row write while busy");
    write_cmd(2'd2);
    check("R8 cmd write while busy", 64'(cmd_rd), 64'd1);
    hdr();
    check("R3 trigger after busy writes", 64'(act_pulse), 64'd1);
    hdr();
    commit_model();
    check_tables("R4 copy after busy writes");
    for (int k = 0; k < KEEP; k++) hdr();

    // R8: code 3 and code 0 do nothing
    write_cmd(2'd3);
    check("R8 code3 cmd", 64'(cmd_rd), 64'd0);
    check("R8 code3 busy", 64'(busy), 64'd0);
    write_cmd(2'd0);
    check("R8 code0 busy", 64'(busy), 64'd0);
    hdr();
    check_tables("R8 no copy");
    check("R8 no keepout", 64'(keepout), 64'd0);

    // R9 exact window
    write_row(2'd0, 6'd2, 6'd2);
    e_ps[0] = 6'd2; e_pn[0] = 6'd2;
    run_update(2'd2, "R9 window");
    for (int k = 0; k < KEEP - 1; k++) hdr();
    check("R9 high after 15 headers", 64'(keepout), 64'd1);
    repeat (3) @(negedge clk);
    check("R9 held without headers", 64'(keepout), 64'd1);
    hdr();
    check("R9 low after 16th header", 64'(keepout), 64'd0);

    // R11 restart during keepout
    run_update(2'd2, "R11 first");
    for (int k = 0; k < 10; k++) hdr();
    run_update(2'd2, "R11 second");
    for (int k = 0; k < KEEP - 1; k++) hdr();
    check("R11 still high after restart", 64'(keepout), 64'd1);
    hdr();
    check("R11 low after full window", 64'(keepout), 64'd0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule